// File: doc/BRIEF.md
# Windowed Data Local Store for a Vertical-Microcode Engine

This block is the register file a vertical-microcode execution engine uses for its operands. It holds 48 entries of 32 bits and has two combinational read ports and one write port that updates on the clock edge. A port given a full 6-bit address reaches any entry directly. Sense/control and branch microinstructions use this form.

Compact ALU, shift and load/store microinstructions give each operand as a 3-bit slot. The block turns that slot into a physical entry through a window. In trap level the window covers the eight trap registers. In base level the window covers either the eight work registers, or six work registers plus two slots that point indirectly at a general or floating-point register named by the host instruction's R1 field. A one-bit level register is set by an enter-trap pulse and cleared by a return pulse.

A full address outside the file is rejected. It reads as zero, its write is dropped, and a one-cycle error pulse is raised.

Top module: `ustore_window_rf`

## Requirements
- R1: After reset every entry reads zero, the level is base, and `addr_err_o` is low.
- R2: A port with its full flag set uses its 6-bit address as the entry number for addresses 0 to 47. A write lands on the clock edge and is visible from the next cycle.
- R3: A full address of 48 or more reads as 0 and its write changes no entry. `addr_err_o` is high in exactly the cycle after such an access, on any port, and is low otherwise.
- R4: In trap level, compact slot s (0 to 7) addresses entry 24+s, whatever the window inputs are.
- R5: In base level with `win_split_i`=0, compact slot s addresses entry 32+s.
- R6: In base level with `win_split_i`=1, slots 0 to 5 address entries 32 to 37. Slot 6 addresses register R1 of the class and slot 7 addresses register R1+1, wrapping within the class. With `fpr_sel_i`=0 the class is the general registers (entries 0 to 15, wrap modulo 16). With `fpr_sel_i`=1 the class is the floating-point registers (entry 16+(index mod 8)).
- R7: `trap_enter_i` sets the level to trap and `trap_return_i` clears it. When both are high, enter wins. The new level steers mapping from the cycle after the pulse, and mapping during the pulse cycle still uses the old level.
- R8: When a read and a legal write reach the same entry in one cycle, the read port returns the write data in that cycle.
- R9: A compact write address is mapped by the same window rules as a compact read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trap_enter_i | input | 1 | Pulse: enter trap level |
| trap_return_i | input | 1 | Pulse: return to base level |
| r1_i | input | 4 | R1 field of the host instruction |
| fpr_sel_i | input | 1 | Indirect class: 0 general, 1 floating-point |
| win_split_i | input | 1 | Base window: 0 eight work slots, 1 six work plus two indirect |
| rd_a_full_i | input | 1 | Read port A uses the full address |
| rd_a_addr_i | input | 6 | Read port A address (low 3 bits when compact) |
| rd_a_data_o | output | 32 | Read port A data |
| rd_b_full_i | input | 1 | Read port B uses the full address |
| rd_b_addr_i | input | 6 | Read port B address (low 3 bits when compact) |
| rd_b_data_o | output | 32 | Read port B data |
| wr_en_i | input | 1 | Write enable |
| wr_full_i | input | 1 | Write port uses the full address |
| wr_addr_i | input | 6 | Write address (low 3 bits when compact) |
| wr_data_i | input | 32 | Write data |
| addr_err_o | output | 1 | One-cycle pulse after an out-of-range full address |

## Verification
The bench fills every entry with a value that encodes its own index. It then walks window settings that include the slot-7 wrap at R1=15, the floating-point modulo-8 fold, and trap level ignoring the split and class inputs. A design that got these wrong would return a neighbouring register's value. Illegal addresses 50 and 63 are used because a design that aliases them modulo 32 or 48 would write entry 31 or 15. Such a design would also return data instead of zero, or raise the error in the wrong cycle. The bench also covers simultaneous enter and return pulses, the same-cycle bypass on both the full and the compact path, and a compact write whose slot wraps into the floating-point class. A design that switched level early or skipped the bypass would show stale data.

// File: rtl/ustore_pkg.sv
package ustore_pkg;
  localparam int DW         = 32;
  localparam int NENT       = 48;
  localparam int AW         = $clog2(NENT);
  localparam int SW         = 3;
  localparam int R1W        = 4;
  localparam int NFPR       = 8;
  localparam int FW         = $clog2(NFPR);
  localparam int GPR_BASE   = 0;
  localparam int FPR_BASE   = 16;
  localparam int TRAP_BASE  = 24;
  localparam int WORK_BASE  = 32;
  localparam int SPLIT_SLOT = 6;
  localparam int NUM_RD     = 2;

  typedef logic [AW-1:0] paddr_t;
  typedef logic [DW-1:0] word_t;

  typedef struct packed {
    logic           trap;
    logic           split;
    logic           fpr;
    logic [R1W-1:0] r1;
  } win_ctx_t;
endpackage

// File: rtl/ustore_addr_map.sv
module ustore_addr_map
  import ustore_pkg::*;
(
  input  logic     full_i,
  input  paddr_t   addr_i,
  input  win_ctx_t ctx_i,
  output paddr_t   phys_o,
  output logic     illegal_o
);
  logic [SW-1:0]  slot;
  logic [R1W-1:0] reg_idx;
  logic           bump;

  assign slot    = addr_i[SW-1:0];
  assign bump    = (slot == SW'(SPLIT_SLOT + 1));
  assign reg_idx = ctx_i.r1 + R1W'(bump);  // wraps within 16 general regs

  always_comb begin
    illegal_o = 1'b0;
    if (full_i) begin
      phys_o    = addr_i;
      illegal_o = (addr_i >= AW'(NENT));
    end else if (ctx_i.trap) begin
      phys_o = AW'(TRAP_BASE) + AW'(slot);
    end else if (ctx_i.split && (slot >= SW'(SPLIT_SLOT))) begin
      if (ctx_i.fpr) phys_o = AW'(FPR_BASE) + AW'(reg_idx[FW-1:0]);
      else           phys_o = AW'(GPR_BASE) + AW'(reg_idx);
    end else begin
      phys_o = AW'(WORK_BASE) + AW'(slot);
    end
  end
endmodule

// File: rtl/ustore_level_reg.sv
module ustore_level_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enter_i,
  input  logic return_i,
  output logic trap_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       trap_o <= 1'b0;
    else if (enter_i)  trap_o <= 1'b1;
    else if (return_i) trap_o <= 1'b0;
  end
endmodule

// File: rtl/ustore_reg_array.sv
module ustore_reg_array
  import ustore_pkg::*;
#(
  parameter int N_RD = NUM_RD
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   we_i,
  input  paddr_t waddr_i,
  input  word_t  wdata_i,
  input  paddr_t raddr_i   [N_RD],
  input  logic   rillegal_i[N_RD],
  output word_t  rdata_o   [N_RD]
);
  word_t mem [NENT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NENT; k++) mem[k] <= '0;
    end else if (we_i) begin
      mem[waddr_i] <= wdata_i;
    end
  end

  for (genvar p = 0; p < N_RD; p++) begin : g_rd
    always_comb begin
      if (rillegal_i[p])                     rdata_o[p] = '0;
      else if (we_i && waddr_i == raddr_i[p]) rdata_o[p] = wdata_i;
      else                                    rdata_o[p] = mem[raddr_i[p]];
    end
  end
endmodule

// File: rtl/ustore_window_rf.sv
module ustore_window_rf
  import ustore_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        trap_enter_i,
  input  logic        trap_return_i,
  input  logic [3:0]  r1_i,
  input  logic        fpr_sel_i,
  input  logic        win_split_i,
  input  logic        rd_a_full_i,
  input  logic [5:0]  rd_a_addr_i,
  output logic [31:0] rd_a_data_o,
  input  logic        rd_b_full_i,
  input  logic [5:0]  rd_b_addr_i,
  output logic [31:0] rd_b_data_o,
  input  logic        wr_en_i,
  input  logic        wr_full_i,
  input  logic [5:0]  wr_addr_i,
  input  logic [31:0] wr_data_i,
  output logic        addr_err_o
);
  localparam int NPORT = NUM_RD + 1;  // last index is the write port

  logic     trap_lvl;
  win_ctx_t ctx;
  logic     p_full   [NPORT];
  paddr_t   p_addr   [NPORT];
  paddr_t   p_phys   [NPORT];
  logic     p_ill    [NPORT];
  paddr_t   rd_phys  [NUM_RD];
  logic     rd_ill   [NUM_RD];
  word_t    rd_data  [NUM_RD];
  logic     wr_ok;
  logic     err_q;

  ustore_level_reg u_level (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .enter_i (trap_enter_i),
    .return_i(trap_return_i),
    .trap_o  (trap_lvl)
  );

  assign ctx = '{trap: trap_lvl, split: win_split_i, fpr: fpr_sel_i, r1: r1_i};

  assign p_full[0] = rd_a_full_i;
  assign p_addr[0] = rd_a_addr_i;
  assign p_full[1] = rd_b_full_i;
  assign p_addr[1] = rd_b_addr_i;
  assign p_full[2] = wr_full_i;
  assign p_addr[2] = wr_addr_i;

  for (genvar p = 0; p < NPORT; p++) begin : g_map
    ustore_addr_map u_map (
      .full_i   (p_full[p]),
      .addr_i   (p_addr[p]),
      .ctx_i    (ctx),
      .phys_o   (p_phys[p]),
      .illegal_o(p_ill[p])
    );
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rdsel
    assign rd_phys[p] = p_phys[p];
    assign rd_ill[p]  = p_ill[p];
  end

  assign wr_ok = wr_en_i && !p_ill[NUM_RD];

  ustore_reg_array #(.N_RD(NUM_RD)) u_array (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (wr_ok),
    .waddr_i   (p_phys[NUM_RD]),
    .wdata_i   (wr_data_i),
    .raddr_i   (rd_phys),
    .rillegal_i(rd_ill),
    .rdata_o   (rd_data)
  );

  assign rd_a_data_o = rd_data[0];
  assign rd_b_data_o = rd_data[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= p_ill[0] || p_ill[1] || (wr_en_i && p_ill[NUM_RD]);
  end

  assign addr_err_o = err_q;
endmodule

// File: rtl/ustore_window_rf_chk.sv
module ustore_window_rf_chk
  import ustore_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        trap_enter_i,
  input logic        trap_return_i,
  input logic        trap_lvl,
  input logic        rd_a_full_i,
  input logic [5:0]  rd_a_addr_i,
  input logic [31:0] rd_a_data_o,
  input logic        rd_b_full_i,
  input logic [5:0]  rd_b_addr_i,
  input logic [31:0] rd_b_data_o,
  input logic        wr_en_i,
  input logic        wr_full_i,
  input logic [5:0]  wr_addr_i,
  input logic [31:0] wr_data_i,
  input logic        addr_err_o
);
  logic bad_any;
  assign bad_any = (rd_a_full_i && rd_a_addr_i >= 6'(NENT)) ||
                   (rd_b_full_i && rd_b_addr_i >= 6'(NENT)) ||
                   (wr_en_i && wr_full_i && wr_addr_i >= 6'(NENT));

  AST_BAD_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_a_full_i && rd_a_addr_i >= 6'(NENT)) |-> rd_a_data_o == 32'd0); // R3
  AST_ERR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_any |=> addr_err_o); // R3
  AST_ERR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bad_any |=> !addr_err_o); // R3
  AST_TRAP_ENTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_enter_i |=> trap_lvl); // R7
  AST_TRAP_RETURN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_return_i && !trap_enter_i) |=> !trap_lvl); // R7
  AST_BYPASS_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_full_i && rd_b_full_i && rd_b_addr_i == wr_addr_i &&
     wr_addr_i < 6'(NENT)) |-> rd_b_data_o == wr_data_i); // R8
endmodule

bind ustore_window_rf ustore_window_rf_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .trap_enter_i (trap_enter_i),
  .trap_return_i(trap_return_i),
  .trap_lvl     (trap_lvl),
  .rd_a_full_i  (rd_a_full_i),
  .rd_a_addr_i  (rd_a_addr_i),
  .rd_a_data_o  (rd_a_data_o),
  .rd_b_full_i  (rd_b_full_i),
  .rd_b_addr_i  (rd_b_addr_i),
  .rd_b_data_o  (rd_b_data_o),
  .wr_en_i      (wr_en_i),
  .wr_full_i    (wr_full_i),
  .wr_addr_i    (wr_addr_i),
  .wr_data_i    (wr_data_i),
  .addr_err_o   (addr_err_o)
);

// File: tb/ustore_window_rf_tb_top.sv
`timescale 1ns/1ps
module ustore_window_rf_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trap_enter = 0, trap_return = 0;
  logic [3:0]  r1 = 0;
  logic        fpr_sel = 0, win_split = 0;
  logic        a_full = 0, b_full = 0;
  logic [5:0]  a_addr = 0, b_addr = 0;
  logic [31:0] a_data, b_data;
  logic        wr_en = 0, wr_full = 0;
  logic [5:0]  wr_addr = 0;
  logic [31:0] wr_data = 0;
  logic        addr_err;

  int errors = 0;
  int checks = 0;
  logic lvl_now = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  ustore_window_rf dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .trap_enter_i(trap_enter), .trap_return_i(trap_return),
    .r1_i(r1), .fpr_sel_i(fpr_sel), .win_split_i(win_split),
    .rd_a_full_i(a_full), .rd_a_addr_i(a_addr), .rd_a_data_o(a_data),
    .rd_b_full_i(b_full), .rd_b_addr_i(b_addr), .rd_b_data_o(b_data),
    .wr_en_i(wr_en), .wr_full_i(wr_full), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .addr_err_o(addr_err)
  );

  // {trap, split, fpr, r1[3:0], slot[2:0], entry[5:0]}
  localparam int NV = 13;
  localparam logic [15:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b0, 4'd0,  3'd0, 6'd32},
    {1'b0, 1'b0, 1'b1, 4'd9,  3'd7, 6'd39},
    {1'b0, 1'b1, 1'b0, 4'd5,  3'd5, 6'd37},
    {1'b0, 1'b1, 1'b0, 4'd5,  3'd6, 6'd5},
    {1'b0, 1'b1, 1'b0, 4'd5,  3'd7, 6'd6},
    {1'b0, 1'b1, 1'b0, 4'd15, 3'd7, 6'd0},
    {1'b0, 1'b1, 1'b1, 4'd3,  3'd6, 6'd19},
    {1'b0, 1'b1, 1'b1, 4'd7,  3'd7, 6'd16},
    {1'b0, 1'b1, 1'b1, 4'd12, 3'd6, 6'd20},
    {1'b1, 1'b0, 1'b0, 4'd0,  3'd0, 6'd24},
    {1'b1, 1'b0, 1'b0, 4'd0,  3'd7, 6'd31},
    {1'b1, 1'b1, 1'b1, 4'd3,  3'd6, 6'd30},
    {1'b1, 1'b1, 1'b0, 4'd15, 3'd7, 6'd31}
  };

  function automatic logic [31:0] pat(input int i);
    return 32'h5A00_0000 | 32'(i);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_full(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_full = 1; wr_addr = 6'(a); wr_data = d;
    @(negedge clk);
    wr_en = 0; wr_full = 0;
  endtask

  task automatic set_level(input logic t);
    if (lvl_now != t) begin
      @(negedge clk);
      trap_enter = t; trap_return = !t;
      @(negedge clk);
      trap_enter = 0; trap_return = 0;
      lvl_now = t;
    end
  endtask

  task automatic read_full_a(input int a);
    @(negedge clk);
    a_full = 1; a_addr = 6'(a);
    #3;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state
    @(negedge clk);
    a_full = 1; a_addr = 6'd0; b_full = 1; b_addr = 6'd47;
    #3;
    chk("R1 entry0", a_data, 32'd0);
    chk("R1 entry47", b_data, 32'd0);
    chk("R1 err low", 32'(addr_err), 32'd0);

    // R2: fill every entry, read back on alternating ports
    for (int i = 0; i < 48; i++) write_full(i, pat(i));
    for (int i = 0; i < 48; i++) begin
      @(negedge clk);
      a_full = 1; b_full = 1; a_addr = 6'(i); b_addr = 6'(47 - i);
      #3;
      chk("R2 port a", a_data, pat(i));
      chk("R2 port b", b_data, pat(47 - i));
    end
    @(negedge clk);
    a_full = 0; b_full = 0;

    // R1/R4/R5/R6: window table (first vectors run at reset level: base)
    for (int v = 0; v < NV; v++) begin
      logic [15:0] e;
      string tag;
      e = VEC[v];
      set_level(e[15]);
      @(negedge clk);
      win_split = e[14]; fpr_sel = e[13]; r1 = e[12:9];
      a_full = 0; b_full = 0; a_addr = {3'b0, e[8:6]}; b_addr = {3'b111, e[8:6]};
      #3;
      tag = e[15] ? "R4 trap window" : (e[14] ? "R6 split window" : "R5 work window");
      if (v == 0) tag = "R1 R5 base after reset";
      chk(tag, a_data, pat(int'(e[5:0])));
      chk(tag, b_data, pat(int'(e[5:0])));
    end
    set_level(1'b0);
    @(negedge clk);
    win_split = 0; fpr_sel = 0; r1 = 0;

    // R3: illegal read
    read_full_a(50);
    chk("R3 bad read zero", a_data, 32'd0);
    chk("R3 err not yet", 32'(addr_err), 32'd0);
    @(negedge clk);
    a_full = 0; a_addr = 0;
    #3;
    chk("R3 err pulse", 32'(addr_err), 32'd1);
    @(negedge clk);
    #3;
    chk("R3 err one cycle", 32'(addr_err), 32'd0);

    // R3: illegal write must not alias
    @(negedge clk);
    wr_en = 1; wr_full = 1; wr_addr = 6'd63; wr_data = 32'hDEAD_BEEF;
    @(negedge clk);
    wr_en = 0; wr_full = 0;
    #3;
    chk("R3 err after bad write", 32'(addr_err), 32'd1);
    read_full_a(15);
    chk("R3 entry15 kept", a_data, pat(15));
    read_full_a(31);
    chk("R3 entry31 kept", a_data, pat(31));
    read_full_a(47);
    chk("R3 entry47 kept", a_data, pat(47));

    // R7: both pulses, enter wins, takes effect next cycle
    @(negedge clk);
    a_full = 0; a_addr = 6'd0; trap_enter = 1; trap_return = 1;
    #3;
    chk("R7 old level in pulse cycle", a_data, pat(32));
    @(negedge clk);
    trap_enter = 0; trap_return = 0;
    #3;
    chk("R7 enter wins", a_data, pat(24));
    @(negedge clk);
    trap_return = 1;
    @(negedge clk);
    trap_return = 0;
    #3;
    chk("R7 return to base", a_data, pat(32));

    // R8: bypass on full path
    @(negedge clk);
    a_full = 1; a_addr = 6'd40;
    wr_en = 1; wr_full = 1; wr_addr = 6'd40; wr_data = 32'h1234_5678;
    #3;
    chk("R8 bypass full", a_data, 32'h1234_5678);
    @(negedge clk);
    wr_en = 0; wr_full = 0;
    #3;
    chk("R2 written value held", a_data, 32'h1234_5678);

    // R8: bypass on compact path in trap level (slot 3 -> 27)
    set_level(1'b1);
    @(negedge clk);
    a_full = 0; b_full = 0; b_addr = 6'd3;
    wr_en = 1; wr_full = 1; wr_addr = 6'd27; wr_data = 32'hCAFE_0027;
    #3;
    chk("R8 bypass compact", b_data, 32'hCAFE_0027);
    @(negedge clk);
    wr_en = 0; wr_full = 0;
    set_level(1'b0);

    // R9: compact write in split FPR window, slot 7 with r1=7 -> entry 16
    @(negedge clk);
    win_split = 1; fpr_sel = 1; r1 = 4'd7;
    wr_en = 1; wr_full = 0; wr_addr = 6'd7; wr_data = 32'hF00D_0016;
    @(negedge clk);
    wr_en = 0;
    read_full_a(16);
    chk("R9 compact write wraps", a_data, 32'hF00D_0016);
    read_full_a(23);
    chk("R9 neighbour untouched", a_data, pat(23));

    @(negedge clk);
    a_full = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule